// File: doc/BRIEF.md
# Ping-Pong Integrator Phase Controller

This block sequences the digital switch controls of one sampling channel built around two integrators that take turns. In every integration interval one integrator accumulates the modulated input while the other first holds its result for the converter and is then cleared. The block only produces the control signals. The analog switches, the follower and the converter sit outside it.

The block flips the roles of the two integrators at every interval strobe, so there is never a gap in integration. It measures how many chip periods the previous interval lasted and uses that count to place the clear pulse of the idle side at the end of its hold phase. The clear pulse lasts a programmed number of chip periods.

It also drives three two-wire control pairs through break-before-make stages with a programmable dead time:

- the modulator's true/complement chip drive, which is active high;
- the integrator selects, which are active low;
- the follower input selects, which are active low.

Top module: `pingpong_phase_ctl`

## Requirements
- R1: While reset is applied, every pair is inactive: `chip_p`=0, `chip_n`=0, and all four active-low selects are 1. Both clears are 1 and `out_sel`=1.
- R2: The integrating side starts as left (`int_sel_l_n`=0) and swaps at every `intv_stb`. `out_sel` toggles exactly on the clock after each strobe and is stable otherwise. Once a swap has settled, `int_sel_l_n`=0 when left integrates and `int_sel_r_n`=0 when right integrates.
- R3: `out_sel`=1 routes the right integrator to the converter and `out_sel`=0 routes the left one. The holding side is always the one routed, and once settled its active-low follower select is 0.
- R4: Let L be the number of `chip_stb` pulses counted in the previous interval, where a chip pulse that coincides with the interval strobe counts toward the interval it ends. Let k be the number of chip pulses seen in the current interval. The clear of the holding side is 1 while k + rlen ≥ L, and 0 before that. It drops when the next interval starts. The integrating side is never cleared.
- R5: A `rst_len` of 0 acts as a clear length of 1 chip period.
- R6: From reset until the first `intv_stb`, both `clr_l` and `clr_r` are 1.
- R7: `chip_p` and `chip_n` are never both 1. Once settled, `chip_p`=`chip_bit` and `chip_n`=!`chip_bit`.
- R8: `int_sel_l_n` and `int_sel_r_n` are never both 0.
- R9: `out_sel_l_n` and `out_sel_r_n` are never both 0.
- R10: Whenever a pair hands over from one wire to the other, both wires are inactive for exactly D clock cycles. D is `dead_sel` (1 to 3), and a code of 0 gives D=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_stb | input | 1 | One-cycle pulse per chip period |
| intv_stb | input | 1 | One-cycle pulse at each interval boundary |
| chip_bit | input | 1 | Current chipping value (1 = +1, 0 = -1) |
| rst_len | input | RLW | Clear length in chip periods (0 acts as 1) |
| dead_sel | input | DW | Dead time in clock cycles (0 acts as 1) |
| chip_p | output | 1 | Modulator true drive, active high |
| chip_n | output | 1 | Modulator complement drive, active high |
| int_sel_l_n | output | 1 | Left integrator select, active low |
| int_sel_r_n | output | 1 | Right integrator select, active low |
| out_sel | output | 1 | Follower routing: 1 = right, 0 = left |
| out_sel_l_n | output | 1 | Follower left input switch, active low |
| out_sel_r_n | output | 1 | Follower right input switch, active low |
| clr_l | output | 1 | Left integrator clear, active high |
| clr_r | output | 1 | Right integrator clear, active high |

## Verification
The bench builds the block with its defaults: an 8-bit chip counter, a 4-bit clear length and a 2-bit dead-time code. With those widths every clear-length case is reachable:

- zero, which is promoted to one;
- a length shorter than the interval;
- a length of 15, which exceeds a six-chip interval, so the holding side stays cleared for the whole interval.

The 2-bit code also covers every dead time, from the promoted zero up to three cycles. At three cycles, chip-bit changes every three clocks restart a handover as soon as the previous one ends. A four-chip interval run after six-chip runs checks that the measured length follows the strobe spacing.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  // Which integrator is currently accumulating.
  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Two-wire request: bit 0 = first wire, bit 1 = second wire, one-hot.
  typedef logic [1:0] pair_t;

  localparam pair_t PAIR_A = 2'b01;
  localparam pair_t PAIR_B = 2'b10;
  localparam pair_t PAIR_NONE = 2'b00;

endpackage

// File: rtl/ppc_break_pair.sv
module ppc_break_pair
  import pingpong_pkg::*;
#(
  parameter int DW      = 2,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rs_n,
  input  pair_t         want,
  input  logic [DW-1:0] dead,
  output logic          out_a,
  output logic          out_b
);

  localparam logic [DW-1:0] ONE_W = DW'(1);

  pair_t         act_q, act_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dead_eff;
  logic          busy;

  assign dead_eff = (dead == '0) ? ONE_W : dead;
  assign busy     = (act_q != want);

  // Break first, wait the dead time, then make.
  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (busy) begin
      if (act_q != PAIR_NONE) begin
        act_d = PAIR_NONE;
        cnt_d = dead_eff - ONE_W;
      end else if (cnt_q == '0) begin
        act_d = want;
      end else begin
        cnt_d = cnt_q - ONE_W;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      act_q <= PAIR_NONE;
      cnt_q <= '0;
    end else if (busy) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    if (ACT_LOW) begin : g_low
      assign out_a = ~act_q[0];
      assign out_b = ~act_q[1];
    end else begin : g_high
      assign out_a = act_q[0];
      assign out_b = act_q[1];
    end
  endgenerate

endmodule

// File: rtl/ppc_interval_seq.sv
module ppc_interval_seq
  import pingpong_pkg::*;
#(
  parameter int CW  = 8,
  parameter int RLW = 4
) (
  input  logic           clk,
  input  logic           rs_n,
  input  logic           chip_stb,
  input  logic           intv_stb,
  input  logic [RLW-1:0] rlen,
  output side_e          side_o,
  output logic           first_o,
  output logic           clr_l,
  output logic           clr_r
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  side_e          side_q, side_d;
  logic           first_q, first_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  last_q, last_d;
  logic [CW-1:0]  rlen_eff;
  logic [CW:0]    reach;
  logic           window;
  logic           upd;

  assign upd = intv_stb | chip_stb;

  always_comb begin
    side_d  = side_q;
    first_d = first_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    if (intv_stb) begin
      side_d  = (side_q == SIDE_L) ? SIDE_R : SIDE_L;
      first_d = 1'b0;
      cnt_d   = '0;
      last_d  = (chip_stb && cnt_q != CNT_MAX) ? cnt_q + ONE_C : cnt_q;
    end else if (chip_stb && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      side_q  <= SIDE_L;
      first_q <= 1'b1;
      cnt_q   <= '0;
      last_q  <= '0;
    end else if (upd) begin
      side_q  <= side_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
    end
  end

  // Clear window: remaining chips of the interval fit within the clear length.
  assign rlen_eff = (rlen == '0) ? ONE_C : CW'(rlen);
  assign reach    = {1'b0, cnt_q} + {1'b0, rlen_eff};
  assign window   = (last_q != '0) && (reach >= {1'b0, last_q});

  assign clr_l   = first_q | ((side_q == SIDE_R) & window);
  assign clr_r   = first_q | ((side_q == SIDE_L) & window);
  assign side_o  = side_q;
  assign first_o = first_q;

endmodule

// File: rtl/pingpong_phase_ctl.sv
module pingpong_phase_ctl
  import pingpong_pkg::*;
#(
  parameter int CW  = 8,
  parameter int RLW = 4,
  parameter int DW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chip_stb,
  input  logic           intv_stb,
  input  logic           chip_bit,
  input  logic [RLW-1:0] rst_len,
  input  logic [DW-1:0]  dead_sel,
  output logic           chip_p,
  output logic           chip_n,
  output logic           int_sel_l_n,
  output logic           int_sel_r_n,
  output logic           out_sel,
  output logic           out_sel_l_n,
  output logic           out_sel_r_n,
  output logic           clr_l,
  output logic           clr_r
);

  logic [1:0] rsync_q;
  logic       rs_n;
  side_e      side;
  logic       first_w;
  pair_t      want_chip, want_int, want_out;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rs_n = rsync_q[1];

  ppc_interval_seq #(.CW(CW), .RLW(RLW)) u_seq (
    .clk      (clk),
    .rs_n     (rs_n),
    .chip_stb (chip_stb),
    .intv_stb (intv_stb),
    .rlen     (rst_len),
    .side_o   (side),
    .first_o  (first_w),
    .clr_l    (clr_l),
    .clr_r    (clr_r)
  );

  assign want_chip = chip_bit ? PAIR_A : PAIR_B;
  assign want_int  = (side == SIDE_L) ? PAIR_A : PAIR_B;
  assign want_out  = (side == SIDE_L) ? PAIR_B : PAIR_A;
  assign out_sel   = (side == SIDE_L);

  ppc_break_pair #(.DW(DW), .ACT_LOW(1'b0)) u_chip (
    .clk (clk), .rs_n (rs_n), .want (want_chip), .dead (dead_sel),
    .out_a (chip_p), .out_b (chip_n)
  );

  ppc_break_pair #(.DW(DW), .ACT_LOW(1'b1)) u_int (
    .clk (clk), .rs_n (rs_n), .want (want_int), .dead (dead_sel),
    .out_a (int_sel_l_n), .out_b (int_sel_r_n)
  );

  ppc_break_pair #(.DW(DW), .ACT_LOW(1'b1)) u_out (
    .clk (clk), .rs_n (rs_n), .want (want_out), .dead (dead_sel),
    .out_a (out_sel_l_n), .out_b (out_sel_r_n)
  );

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker (
  input logic clk,
  input logic rs_n,
  input logic intv_stb,
  input logic first_w,
  input logic chip_p,
  input logic chip_n,
  input logic int_sel_l_n,
  input logic int_sel_r_n,
  input logic out_sel,
  input logic out_sel_l_n,
  input logic out_sel_r_n,
  input logic clr_l,
  input logic clr_r
);

  AST_CHIP_EXCL: assert property (@(posedge clk) disable iff (!rs_n)
    !(chip_p && chip_n)); // R7

  AST_INT_EXCL: assert property (@(posedge clk) disable iff (!rs_n)
    !(!int_sel_l_n && !int_sel_r_n)); // R8

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rs_n)
    !(!out_sel_l_n && !out_sel_r_n)); // R9

  AST_ROLE_SWAP: assert property (@(posedge clk) disable iff (!rs_n)
    intv_stb |=> (out_sel != $past(out_sel))); // R2

  AST_ROLE_KEEP: assert property (@(posedge clk) disable iff (!rs_n)
    !intv_stb |=> $stable(out_sel)); // R2

  AST_LEFT_RUNS: assert property (@(posedge clk) disable iff (!rs_n)
    (!first_w && out_sel) |-> !clr_l); // R4

  AST_RIGHT_RUNS: assert property (@(posedge clk) disable iff (!rs_n)
    (!first_w && !out_sel) |-> !clr_r); // R4

  AST_FIRST_CLR: assert property (@(posedge clk) disable iff (!rs_n)
    first_w |-> (clr_l && clr_r)); // R6

endmodule

bind pingpong_phase_ctl ppc_checker u_chk (
  .clk         (clk),
  .rs_n        (rs_n),
  .intv_stb    (intv_stb),
  .first_w     (first_w),
  .chip_p      (chip_p),
  .chip_n      (chip_n),
  .int_sel_l_n (int_sel_l_n),
  .int_sel_r_n (int_sel_r_n),
  .out_sel     (out_sel),
  .out_sel_l_n (out_sel_l_n),
  .out_sel_r_n (out_sel_r_n),
  .clr_l       (clr_l),
  .clr_r       (clr_r)
);

// File: tb/sim_pingpong_phase_ctl.sv
module sim_pingpong_phase_ctl;

  localparam int CLK_NS = 10;
  localparam int CW = 8;
  localparam int RLW = 4;
  localparam int DW = 2;

  logic clk, rst_n, chip_stb, intv_stb, chip_bit;
  logic [RLW-1:0] rst_len;
  logic [DW-1:0] dead_sel;
  logic chip_p, chip_n, int_sel_l_n, int_sel_r_n, out_sel;
  logic out_sel_l_n, out_sel_r_n, clr_l, clr_r;

  pingpong_phase_ctl #(.CW(CW), .RLW(RLW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .intv_stb(intv_stb),
    .chip_bit(chip_bit), .rst_len(rst_len), .dead_sel(dead_sel),
    .chip_p(chip_p), .chip_n(chip_n), .int_sel_l_n(int_sel_l_n),
    .int_sel_r_n(int_sel_r_n), .out_sel(out_sel), .out_sel_l_n(out_sel_l_n),
    .out_sel_r_n(out_sel_r_n), .clr_l(clr_l), .clr_r(clr_r)
  );

  typedef struct {
    bit rl; bit rr; bit side; bit bitv; bit first; bit r0;
    int sage; int bage; int deff;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state built from the requirements.
  bit m_side, m_first, m_bit;
  int m_cnt, m_last, m_sage, m_bage;
  logic [15:0] lfsr = 16'hACE1;
  int gap_c, gap_i, gap_o;

  initial clk = 0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
  task automatic cyc(input bit cs, input bit is, input bit cb);
    exp_t e;
    int r;
    @(negedge clk);
    chip_stb = cs; intv_stb = is; chip_bit = cb;
    @(posedge clk);
    if (cb != m_bit) begin m_bit = cb; m_bage = 0; end else m_bage++;
    if (is) begin
      m_side = ~m_side; m_sage = 0; m_first = 0;
      m_last = (cs && m_cnt < 255) ? m_cnt + 1 : m_cnt;
      m_cnt = 0;
    end else begin
      m_sage++;
      if (cs && m_cnt < 255) m_cnt++;
    end
    r = (rst_len == 0) ? 1 : int'(rst_len);
    e.first = m_first;
    e.r0 = (rst_len == 0);
    e.rl = m_first || (m_side && m_last != 0 && m_cnt + r >= m_last);
    e.rr = m_first || (!m_side && m_last != 0 && m_cnt + r >= m_last);
    e.side = m_side; e.bitv = m_bit; e.sage = m_sage; e.bage = m_bage;
    e.deff = (dead_sel == 0) ? 1 : int'(dead_sel);
    q.push_back(e);
  endtask

  task automatic gap_step(input string tag, input bit idle, inout int g, input int d);
    if (idle) g++;
    else begin
      if (g > 0) check(tag, g, d);
      g = 0;
    end
  endtask

  // Monitor: pop one expectation per clock and compare away from the edge.
  initial begin
    exp_t e;
    string t;
    gap_c = 0; gap_i = 0; gap_o = 0;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        t = e.first ? "R6 clear" : (e.r0 ? "R5 clear" : "R4 clear");
        check({t, " left"}, clr_l, e.rl);
        check({t, " right"}, clr_r, e.rr);
        check("R3 out_sel routes holding side", out_sel, !e.side);
        check("R7 chip pair exclusive", chip_p & chip_n, 0);
        check("R8 integrate selects exclusive", !int_sel_l_n & !int_sel_r_n, 0);
        check("R9 follower selects exclusive", !out_sel_l_n & !out_sel_r_n, 0);
        if (e.bage >= 5) begin
          check("R7 chip_p follows bit", chip_p, e.bitv);
          check("R7 chip_n complements bit", chip_n, !e.bitv);
        end
        if (e.sage >= 5) begin
          check("R2 left integrate select", int_sel_l_n, e.side);
          check("R2 right integrate select", int_sel_r_n, !e.side);
          check("R3 follower right select", out_sel_r_n, e.side);
          check("R3 follower left select", out_sel_l_n, !e.side);
        end
        gap_step("R10 chip pair dead time", !chip_p && !chip_n, gap_c, e.deff);
        gap_step("R10 integrate dead time", int_sel_l_n && int_sel_r_n, gap_i, e.deff);
        gap_step("R10 follower dead time", out_sel_l_n && out_sel_r_n, gap_o, e.deff);
      end
    end
  end

  task automatic run(input int n, input int len, input int per);
    bit b;
    b = m_bit;
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < len; c++) begin
        for (int p = 0; p < per; p++) begin
          if (p == 0) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[0];
          end
          cyc(p == 0, p == 0 && c == 0, b);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, m_bit);
  endtask

  task automatic set_cfg(input int r, input int d);
    @(negedge clk);
    rst_len = RLW'(r);
    dead_sel = DW'(d);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chip_stb = 0; intv_stb = 0; chip_bit = 0;
    rst_len = 2; dead_sel = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1 chip_p in reset", chip_p, 0);
    check("R1 chip_n in reset", chip_n, 0);
    check("R1 int_sel_l_n in reset", int_sel_l_n, 1);
    check("R1 int_sel_r_n in reset", int_sel_r_n, 1);
    check("R1 out_sel_l_n in reset", out_sel_l_n, 1);
    check("R1 out_sel_r_n in reset", out_sel_r_n, 1);
    check("R1 clr_l in reset", clr_l, 1);
    check("R1 clr_r in reset", clr_r, 1);
    check("R1 out_sel in reset", out_sel, 1);
    rst_n = 1;
    repeat (4) @(posedge clk);
    m_side = 0; m_first = 1; m_bit = 0; m_cnt = 0; m_last = 0;
    m_sage = 10; m_bage = 10;
    idle(4);
    run(5, 6, 3);
    idle(8);
    set_cfg(0, 0);
    idle(8);
    run(4, 6, 3);
    idle(8);
    set_cfg(15, 3);
    idle(8);
    run(3, 6, 3);
    idle(8);
    set_cfg(1, 1);
    idle(8);
    run(4, 4, 4);
    idle(10);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule